// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

This block is the front end of one DMA channel. After software enables list mode, loads a list pointer and rings a doorbell, the block reads descriptor elements from memory through a simple read port. Each data element becomes one transfer order (source, destination, byte count) on a valid/ready port to a data mover. Each link element redirects the walk to a new address.

Ownership of each element is decided by a cycle bit. An element is used only while its cycle bit equals the consumer cycle state held in the block. A link element with its toggle flag set flips that state. A ring can therefore close on itself: the walker stops cleanly at the first element that software has not yet handed over, and software can refill the ring later without clearing it. The block raises one-cycle pulses for completion interrupts, for a clean halt and for an abort on a memory read error.

Top module: `desc_walker`

## Requirements
- R1: A `doorbell` pulse starts a walk only while the block is idle and `ll_en` is 1. Otherwise it is ignored. A walk starts at the list pointer, whose low half is loaded by `ptr_lo_we` and high half by `ptr_hi_we` from `ptr_wdata`.
- R2: Elements are read as 64-bit little-endian words at element address +0, +8 and +16. Word 0 holds the control word in bits 31:0 and the byte count in bits 63:32. A data element uses word 1 as source and word 2 as destination. A link element uses word 1 as the next-element pointer and is two words long.
- R3: Control word bit 0 is the cycle bit, bit 1 toggle-cycle, bit 2 marks a link, bit 3 requests the stop interrupt and bit 4 the remote interrupt.
- R4: An element whose cycle bit differs from `cyc_state` is not consumed. The walk ends with a one-cycle `halted` pulse, no transfer and no interrupt.
- R5: A data element is offered on `xfer_valid` with its source, destination and byte count, all held stable until `xfer_ready`. The next element is then read at element address + 24.
- R6: A link element moves the walk to its pointer. With toggle-cycle set it inverts `cyc_state`. Without it, `cyc_state` is kept.
- R7: When a data element with bit 3 set is accepted, `irq_stop` pulses for one cycle. `irq_remote` pulses in the same cycle if bit 4 is set.
- R8: A read answered with `rd_err` ends the walk with a one-cycle `irq_abort` pulse. No further transfer follows.
- R9: While idle, `sync_we` loads `cyc_state` from `sync_cycle`. While busy, sync and pointer writes are ignored.
- R10: After reset the block is idle, `cyc_state` is 0 and no request, transfer or pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ll_en | input | 1 | List mode enable |
| ptr_lo_we | input | 1 | Write low half of list pointer |
| ptr_hi_we | input | 1 | Write high half of list pointer |
| ptr_wdata | input | 32 | Pointer half write data |
| sync_we | input | 1 | Write consumer cycle state |
| sync_cycle | input | 1 | Cycle value for sync write |
| doorbell | input | 1 | Start pulse |
| rd_req | output | 1 | Memory read request, held until acknowledged |
| rd_addr | output | 64 | Byte address of the 64-bit word to read |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | 64 | Read data |
| rd_err | input | 1 | Read response is an error |
| xfer_valid | output | 1 | Transfer order valid |
| xfer_ready | input | 1 | Mover accepts and completes the order |
| xfer_src | output | 64 | Source address |
| xfer_dst | output | 64 | Destination address |
| xfer_len | output | 32 | Byte count |
| busy | output | 1 | A walk is in progress |
| cyc_state | output | 1 | Consumer cycle state |
| halted | output | 1 | Pulse: walk ended on an element not owned |
| irq_stop | output | 1 | Pulse: stop interrupt request |
| irq_remote | output | 1 | Pulse: remote interrupt request |
| irq_abort | output | 1 | Pulse: abort on read error |

## Verification
Closed rings of one to four data elements are walked from both starting cycle states. A second pass after software flips only the cycle bits shows that the toggling link makes the ring reusable and that the halt falls exactly on the first element that has not been handed over. A ring whose first element is not owned, a read error inside the second element and a chain hopping through a non-toggling link separate the halt, abort and plain-link paths. A mover stall, with sync and pointer writes made during it, shows that the order is held and that those writes are ignored. A doorbell with list mode off shows the start gate.

// File: rtl/llw_pkg.sv
// Shared definitions for the descriptor walker.
// Assumes: control word bit positions are fixed by the descriptor format.
package llw_pkg;
    localparam int CB_CYCLE  = 0;
    localparam int CB_TOGGLE = 1;
    localparam int CB_LINK   = 2;
    localparam int CB_LIRQ   = 3;
    localparam int CB_RIRQ   = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_MOVE  = 2'd2
    } walk_state_t;
endpackage

// File: rtl/llw_regs.sv
// Software-visible list pointer and consumer cycle state.
// Assumes: writes are accepted only while the walker is idle; the walker
// may toggle the cycle state at any time while busy.
module llw_regs #(
    parameter int ADDR_W = 64,
    localparam int HALF_W = ADDR_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              ptr_lo_we,
    input  logic              ptr_hi_we,
    input  logic [HALF_W-1:0] ptr_wdata,
    input  logic              sync_we,
    input  logic              sync_cycle,
    input  logic              toggle_req,
    output logic [ADDR_W-1:0] list_ptr,
    output logic              cyc_state
);
    // Pointer halves load from software when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            list_ptr <= '0;
        end else if (!busy) begin
            if (ptr_lo_we) list_ptr[HALF_W-1:0]      <= ptr_wdata;
            if (ptr_hi_we) list_ptr[ADDR_W-1:HALF_W] <= ptr_wdata;
        end
    end

    // Cycle state: sync write when idle, toggle from a link while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_state <= 1'b0;
        end else if (toggle_req) begin
            cyc_state <= ~cyc_state;
        end else if (!busy && sync_we) begin
            cyc_state <= sync_cycle;
        end
    end
endmodule

// File: rtl/llw_walker.sv
// Walk state machine: fetches element words, checks ownership, follows
// links and issues transfer orders and interrupt pulses.
// Assumes: one read outstanding; rd_ack may come in the request cycle.
module llw_walker
    import llw_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int WORD_BYTES = 8,
    localparam int WORD_W    = WORD_BYTES * 8,
    localparam int CTRL_W    = WORD_W / 2,
    localparam int ELEM_BYTES = 3 * WORD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ll_en,
    input  logic              doorbell,
    input  logic [ADDR_W-1:0] list_ptr,
    input  logic              cyc_state,
    output logic              toggle_req,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              rd_err,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic [ADDR_W-1:0] xfer_src,
    output logic [ADDR_W-1:0] xfer_dst,
    output logic [CTRL_W-1:0] xfer_len,
    output logic              busy,
    output logic              halted,
    output logic              irq_stop,
    output logic              irq_remote,
    output logic              irq_abort
);
    walk_state_t       state;
    logic [ADDR_W-1:0] cur_ptr;
    logic [1:0]        widx;
    logic [CTRL_W-1:0] ctrl;
    logic              good_rd;

    // Read port and status decode.
    always_comb begin
        rd_req     = (state == ST_FETCH);
        rd_addr    = cur_ptr + ADDR_W'(widx) * ADDR_W'(WORD_BYTES);
        xfer_valid = (state == ST_MOVE);
        busy       = (state != ST_IDLE);
        good_rd    = rd_req && rd_ack && !rd_err;
        toggle_req = good_rd && (widx == 2'd1) && ctrl[CB_LINK] && ctrl[CB_TOGGLE];
    end

    // Walk sequencing and one-cycle event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cur_ptr    <= '0;
            widx       <= '0;
            ctrl       <= '0;
            xfer_len   <= '0;
            xfer_src   <= '0;
            xfer_dst   <= '0;
            halted     <= 1'b0;
            irq_stop   <= 1'b0;
            irq_remote <= 1'b0;
            irq_abort  <= 1'b0;
        end else begin
            halted     <= 1'b0;
            irq_stop   <= 1'b0;
            irq_remote <= 1'b0;
            irq_abort  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (doorbell && ll_en) begin
                        state   <= ST_FETCH;
                        cur_ptr <= list_ptr;
                        widx    <= '0;
                    end
                end
                ST_FETCH: begin
                    if (rd_ack && rd_err) begin
                        irq_abort <= 1'b1;
                        state     <= ST_IDLE;
                    end else if (rd_ack) begin
                        case (widx)
                            2'd0: begin
                                ctrl     <= rd_data[CTRL_W-1:0];
                                xfer_len <= rd_data[WORD_W-1:CTRL_W];
                                if (rd_data[CB_CYCLE] != cyc_state) begin
                                    halted <= 1'b1;
                                    state  <= ST_IDLE;
                                end else begin
                                    widx <= 2'd1;
                                end
                            end
                            2'd1: begin
                                if (ctrl[CB_LINK]) begin
                                    cur_ptr <= rd_data[ADDR_W-1:0];
                                    widx    <= 2'd0;
                                end else begin
                                    xfer_src <= rd_data[ADDR_W-1:0];
                                    widx     <= 2'd2;
                                end
                            end
                            default: begin
                                xfer_dst <= rd_data[ADDR_W-1:0];
                                widx     <= 2'd0;
                                state    <= ST_MOVE;
                            end
                        endcase
                    end
                end
                ST_MOVE: begin
                    if (xfer_ready) begin
                        irq_stop   <= ctrl[CB_LIRQ];
                        irq_remote <= ctrl[CB_RIRQ];
                        cur_ptr    <= cur_ptr + ADDR_W'(ELEM_BYTES);
                        state      <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/desc_walker.sv
// Top of the single-channel linked-list descriptor walker.
// Assumes: ADDR_W is twice the pointer-half width and fits one memory word.
module desc_walker #(
    parameter int ADDR_W     = 64,
    parameter int WORD_BYTES = 8,
    localparam int HALF_W    = ADDR_W / 2,
    localparam int WORD_W    = WORD_BYTES * 8,
    localparam int LEN_W     = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ll_en,
    input  logic              ptr_lo_we,
    input  logic              ptr_hi_we,
    input  logic [HALF_W-1:0] ptr_wdata,
    input  logic              sync_we,
    input  logic              sync_cycle,
    input  logic              doorbell,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              rd_err,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic [ADDR_W-1:0] xfer_src,
    output logic [ADDR_W-1:0] xfer_dst,
    output logic [LEN_W-1:0]  xfer_len,
    output logic              busy,
    output logic              cyc_state,
    output logic              halted,
    output logic              irq_stop,
    output logic              irq_remote,
    output logic              irq_abort
);
    logic [ADDR_W-1:0] list_ptr;
    logic              toggle_req;

    llw_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .ptr_lo_we(ptr_lo_we), .ptr_hi_we(ptr_hi_we), .ptr_wdata(ptr_wdata),
        .sync_we(sync_we), .sync_cycle(sync_cycle), .toggle_req(toggle_req),
        .list_ptr(list_ptr), .cyc_state(cyc_state)
    );

    llw_walker #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_walker (
        .clk(clk), .rst_n(rst_n), .ll_en(ll_en), .doorbell(doorbell),
        .list_ptr(list_ptr), .cyc_state(cyc_state), .toggle_req(toggle_req),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
        .rd_data(rd_data), .rd_err(rd_err),
        .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
        .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_len(xfer_len),
        .busy(busy), .halted(halted), .irq_stop(irq_stop),
        .irq_remote(irq_remote), .irq_abort(irq_abort)
    );
endmodule

// File: rtl/llw_checker.sv
// Port-level properties of the descriptor walker, bound to its top.
// Assumes: synchronous active-low reset.
module llw_checker #(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ll_en,
    input logic              sync_we,
    input logic              xfer_valid,
    input logic              xfer_ready,
    input logic [ADDR_W-1:0] xfer_src,
    input logic [ADDR_W-1:0] xfer_dst,
    input logic [LEN_W-1:0]  xfer_len,
    input logic              busy,
    input logic              cyc_state,
    input logic              halted,
    input logic              irq_stop,
    input logic              irq_abort
);
    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ll_en) |=> !busy); // R1
    AST_HALT_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!busy && !irq_stop)); // R4
    AST_XFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_src)
                                         && $stable(xfer_dst) && $stable(xfer_len))); // R5
    AST_STOP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stop |-> $past(xfer_valid && xfer_ready)); // R7
    AST_ABORT_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_abort |-> (!busy && !xfer_valid)); // R8
    AST_ONE_END_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_abort, halted})); // R8
    AST_CYCLE_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !sync_we) |=> (cyc_state == $past(cyc_state))); // R9
endmodule

bind desc_walker llw_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ll_en(ll_en), .sync_we(sync_we),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_src(xfer_src),
    .xfer_dst(xfer_dst), .xfer_len(xfer_len), .busy(busy),
    .cyc_state(cyc_state), .halted(halted), .irq_stop(irq_stop),
    .irq_abort(irq_abort)
);

// File: tb/desc_walker_bench.sv
// Self-checking bench: walks rings built in a bench memory model and
// compares transfers and pulses with values computed from the requirements.
module desc_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ll_en = 1'b0, ptr_lo_we = 1'b0, ptr_hi_we = 1'b0;
    logic [31:0] ptr_wdata = '0;
    logic        sync_we = 1'b0, sync_cycle = 1'b0, doorbell = 1'b0;
    logic        rd_req, rd_ack, rd_err;
    logic [63:0] rd_addr, rd_data;
    logic        xfer_valid, xfer_ready = 1'b1;
    logic [63:0] xfer_src, xfer_dst;
    logic [31:0] xfer_len;
    logic        busy, cyc_state, halted, irq_stop, irq_remote, irq_abort;

    logic [63:0] mem [0:511];
    logic [63:0] err_addr = 64'hFFFF_FFFF_FFFF_FFF8;
    int checks = 0, failures = 0, cycles = 0;
    int cap_n = 0, n_stop = 0, n_rem = 0, n_abort = 0, n_halt = 0;
    logic [63:0] cap_src [0:15];
    logic [63:0] cap_dst [0:15];
    logic [31:0] cap_len [0:15];

    always #10 clk = ~clk;

    assign rd_ack  = rd_req;
    assign rd_data = mem[rd_addr[11:3]];
    assign rd_err  = rd_req && (rd_addr == err_addr);

    desc_walker u_desc_walker (.*);

    // Monitor: accepted transfers and event pulses.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst_n) begin
            if (xfer_valid && xfer_ready && cap_n < 16) begin
                cap_src[cap_n] <= xfer_src;
                cap_dst[cap_n] <= xfer_dst;
                cap_len[cap_n] <= xfer_len;
                cap_n <= cap_n + 1;
            end
            if (irq_stop)   n_stop  <= n_stop + 1;
            if (irq_remote) n_rem   <= n_rem + 1;
            if (irq_abort)  n_abort <= n_abort + 1;
            if (halted)     n_halt  <= n_halt + 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Control word: bit0 cycle, bit1 toggle, bit2 link, bit3 stop irq, bit4 remote irq (R3).
    task automatic put_data(input int a, input bit c, input bit li, input bit ri,
                            input logic [31:0] len, input logic [63:0] s, input logic [63:0] d);
        mem[a/8]     = {len, 27'd0, ri, li, 1'b0, 1'b0, c};
        mem[a/8 + 1] = s;
        mem[a/8 + 2] = d;
    endtask

    task automatic put_link(input int a, input bit c, input bit t, input logic [63:0] nxt);
        mem[a/8]     = {32'hDEAD_0000, 27'd0, 1'b0, 1'b0, 1'b1, t, c};
        mem[a/8 + 1] = nxt;
    endtask

    task automatic load_ptr(input logic [63:0] p);
        @(negedge clk); ptr_lo_we = 1'b1; ptr_wdata = p[31:0];
        @(negedge clk); ptr_lo_we = 1'b0; ptr_hi_we = 1'b1; ptr_wdata = p[63:32];
        @(negedge clk); ptr_hi_we = 1'b0;
    endtask

    task automatic do_sync(input bit c);
        @(negedge clk); sync_we = 1'b1; sync_cycle = c;
        @(negedge clk); sync_we = 1'b0;
    endtask

    task automatic clear_counts;
        @(negedge clk);
        cap_n = 0; n_stop = 0; n_rem = 0; n_abort = 0; n_halt = 0;
    endtask

    task automatic ring_and_wait;
        int t = 0;
        @(negedge clk); doorbell = 1'b1;
        @(negedge clk); doorbell = 1'b0;
        while (busy && t < 2000) begin @(negedge clk); t++; end
        if (busy) begin failures++; $display("FAIL walk did not finish"); end
        repeat (3) @(negedge clk);
    endtask

    // Build a closed ring of n data elements from byte address b.
    task automatic build_ring(input int b, input int n, input bit c);
        for (int i = 0; i < n; i++)
            put_data(b + 24*i, c, (i == n-1), 1'b0, 32'(16*(i+1) + n),
                     64'h1000_0000 + 64'(i*64) + 64'(c), 64'h2000_0000 + 64'(i));
        put_link(b + 24*n, c, 1'b1, 64'(b));
    endtask

    task automatic check_ring(input int n, input bit c, input bit c_end);
        chk("R5 transfer count", 64'(cap_n), 64'(n));
        for (int i = 0; i < n && i < 16; i++) begin
            chk("R2 source", cap_src[i], 64'h1000_0000 + 64'(i*64) + 64'(c));
            chk("R2 destination", cap_dst[i], 64'h2000_0000 + 64'(i));
            chk("R2 length", 64'(cap_len[i]), 64'(16*(i+1) + n));
        end
        chk("R7 stop pulses", 64'(n_stop), 64'd1);
        chk("R4 halt pulses", 64'(n_halt), 64'd1);
        chk("R6 cycle toggled", 64'(cyc_state), 64'(c_end));
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 busy", 64'(busy), 64'd0);
        chk("R10 cycle", 64'(cyc_state), 64'd0);
        chk("R10 rd_req", 64'(rd_req), 64'd0);
        chk("R10 xfer_valid", 64'(xfer_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: doorbell with list mode off is ignored
        build_ring(32'h100, 1, 1'b0);
        load_ptr(64'h100);
        @(negedge clk); doorbell = 1'b1;
        @(negedge clk); doorbell = 1'b0;
        chk("R1 no start when disabled", 64'(busy | rd_req), 64'd0);
        ll_en = 1'b1;

        // R2 R3 R5 R6 R7 R4: ring sweep, both start cycles, reuse pass
        for (int c = 0; c < 2; c++) begin
            for (int n = 1; n <= 4; n++) begin
                build_ring(32'h100, n, c[0]);
                load_ptr(64'h100);
                do_sync(c[0]);
                clear_counts();
                ring_and_wait();
                check_ring(n, c[0], ~c[0]);
                build_ring(32'h100, n, ~c[0]);
                clear_counts();
                ring_and_wait();
                check_ring(n, ~c[0], c[0]);
            end
        end

        // R4: first element not owned
        build_ring(32'h100, 2, 1'b1);
        do_sync(1'b0);
        clear_counts();
        ring_and_wait();
        chk("R4 no transfer", 64'(cap_n), 64'd0);
        chk("R4 halted", 64'(n_halt), 64'd1);
        chk("R4 no irq", 64'(n_stop), 64'd0);
        chk("R4 cycle kept", 64'(cyc_state), 64'd0);

        // R8: read error on second element's source word
        build_ring(32'h400, 3, 1'b0);
        load_ptr(64'h400);
        err_addr = 64'h400 + 64'd24 + 64'd8;
        clear_counts();
        ring_and_wait();
        err_addr = 64'hFFFF_FFFF_FFFF_FFF8;
        chk("R8 one transfer", 64'(cap_n), 64'd1);
        chk("R8 abort", 64'(n_abort), 64'd1);
        chk("R8 no halt", 64'(n_halt), 64'd0);
        chk("R8 no stop irq", 64'(n_stop), 64'd0);

        // R6 R7: plain link hop keeps cycle, remote irq
        put_data(32'h600, 1'b1, 1'b0, 1'b0, 32'd7, 64'hA0, 64'hB0);
        put_link(32'h618, 1'b1, 1'b0, 64'h700);
        put_data(32'h700, 1'b1, 1'b1, 1'b1, 32'd9, 64'hA1, 64'hB1);
        put_link(32'h718, 1'b1, 1'b1, 64'h600);
        load_ptr(64'h600);
        do_sync(1'b1);
        clear_counts();
        ring_and_wait();
        chk("R6 plain link count", 64'(cap_n), 64'd2);
        chk("R6 element after link", cap_src[1], 64'hA1);
        chk("R7 remote", 64'(n_rem), 64'd1);
        chk("R7 stop", 64'(n_stop), 64'd1);
        chk("R6 final cycle", 64'(cyc_state), 64'd0);

        // R5 R9: mover stall, sync and pointer writes while busy
        put_data(32'h800, 1'b0, 1'b1, 1'b0, 32'd5, 64'hC0, 64'hD0);
        put_link(32'h818, 1'b0, 1'b1, 64'h800);
        load_ptr(64'h800);
        do_sync(1'b0);
        clear_counts();
        xfer_ready = 1'b0;
        @(negedge clk); doorbell = 1'b1;
        @(negedge clk); doorbell = 1'b0;
        repeat (6) @(negedge clk);
        chk("R5 offered", 64'(xfer_valid), 64'd1);
        chk("R5 held source", xfer_src, 64'hC0);
        sync_we = 1'b1; sync_cycle = 1'b1;
        @(negedge clk); sync_we = 1'b0;
        ptr_lo_we = 1'b1; ptr_wdata = 32'h100;
        @(negedge clk); ptr_lo_we = 1'b0;
        chk("R9 sync ignored busy", 64'(cyc_state), 64'd0);
        chk("R5 still held", xfer_dst, 64'hD0);
        xfer_ready = 1'b1;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R9 cycle after walk", 64'(cyc_state), 64'd1);
        do_sync(1'b0);
        clear_counts();
        ring_and_wait();
        chk("R9 pointer write ignored", cap_src[0], 64'hC0);
        chk("R9 one transfer", 64'(cap_n), 64'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog.
    initial begin
        wait (cycles >= 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule